// File: doc/BRIEF.md
# Low-Power Mode Command Sequencer

This block sits in a mobile DDR SDRAM controller. It runs the memory's two low-power modes: self refresh, which keeps the array contents, and deep power-down, which drops them. The controller asks for entry into either mode or for a wake-up, and reports whether every bank is idle. The sequencer drives the chip-select, row-strobe, column-strobe and write-enable pins, the clock-enable pin (CKE) and an enable for the memory clock. A clock generator feeds back a clock-stable input.

Leaving self refresh is a timed process. The memory clock is turned back on and CKE waits until the clock is reported stable. Only no-operation commands go out for a programmed number of cycles before the controller may issue commands again. Leaving deep power-down needs only CKE to go high. The block then reports that the array contents are gone, and it holds off new commands until the controller acknowledges that it will run a full re-initialization.

Top module: `lpm_seq`

## Requirements
- R1: After reset the block is idle. CKE is high, the pins carry NOP (chip-select low; row-strobe, column-strobe and write-enable high, written {cs,ras,cas,we}=0111), the clock enable is high, `cmdReady` is high and `dataLost` is low.
- R2: In idle, a self-refresh request with `banksIdle` high produces one cycle of the refresh encoding {cs,ras,cas,we}=0001 with CKE low in that same cycle. CKE then stays low until the exit sequence.
- R3: An entry request of either kind made while `banksIdle` is low has no effect. The pins stay NOP, CKE stays high and `cmdReady` stays high until the banks report idle.
- R4: `memClkEn` is low only in the cycles after the self-refresh entry cycle and before wake-up. A wake request turns it high in the next cycle, while CKE is still low.
- R5: On self-refresh exit, CKE rises only in the cycle after `clkStable` is sampled high with the memory clock already enabled. While `clkStable` stays low, CKE stays low.
- R6: From the cycle in which CKE returns high after self refresh, exactly `XSR_CYCLES` cycles of NOP follow with `cmdReady` low. `cmdReady` rises in the cycle after them.
- R7: In idle, a deep power-down request with `banksIdle` high (and no self-refresh request) produces one cycle of {cs,ras,cas,we}=0110 with CKE low. CKE then stays low.
- R8: A wake request in deep power-down raises CKE in the next cycle and sets `dataLost`. `cmdReady` stays low and `dataLost` stays high until `reinitAck` is sampled high. Both then change in the following cycle.
- R9: When both entry requests arrive together with banks idle, self refresh is entered.
- R10: Entry requests made during either low-power mode have no effect. A wake request in idle has no effect.
- R11: `cmdReady` is high only while CKE is high and the pins carry NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqSelfRefresh | input | 1 | Request to enter self refresh |
| reqDeepPd | input | 1 | Request to enter deep power-down |
| reqWake | input | 1 | Request to leave the current low-power mode |
| banksIdle | input | 1 | All banks are precharged |
| clkStable | input | 1 | Memory clock reported stable by the clock generator |
| reinitAck | input | 1 | Controller acknowledges the re-initialization after deep power-down |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memCke | output | 1 | Clock enable to the memory |
| memClkEn | output | 1 | Enable for the memory clock driver |
| cmdReady | output | 1 | A normal command may be issued |
| dataLost | output | 1 | Array contents invalid after deep power-down |

## Verification
The bench builds the sequencer with `XSR_CYCLES` set to 7 instead of the default 24. The exit window is therefore short enough to count edge by edge, and long enough that a counter off by one in either direction, or one that never reloads, gives a wrong count. A second self-refresh pass, taken from the simultaneous-request case, checks that the counter reloads fully after it has run to zero once.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SR_ENTER,
    ST_SR_ACTIVE,
    ST_SR_WAIT_CLK,
    ST_SR_XSR,
    ST_DPD_ENTER,
    ST_DPD_ACTIVE,
    ST_DPD_EXIT
  } lpmState_e;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_REFRESH,
    CMD_DPD
  } memCmd_e;

  // Strobes from control to datapath; every field is registered in the datapath.
  typedef struct packed {
    memCmd_e cmd;
    logic    ckeHigh;
    logic    clkOn;
    logic    readyOn;
    logic    xsrLoad;
    logic    xsrTick;
    logic    lostSet;
    logic    lostClr;
  } dpStrobe_t;

  // Pin pattern {cs, ras, cas, we}, all active low.
  function automatic logic [3:0] cmdPins(memCmd_e c);
    case (c)
      CMD_REFRESH: cmdPins = 4'b0001;
      CMD_DPD:     cmdPins = 4'b0110;
      default:     cmdPins = 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqSelfRefresh,
  input  logic      reqDeepPd,
  input  logic      reqWake,
  input  logic      banksIdle,
  input  logic      clkStable,
  input  logic      reinitAck,
  input  logic      xsrZero,
  output dpStrobe_t strobes
);

  lpmState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (banksIdle) begin
          if (reqSelfRefresh)  nextState = ST_SR_ENTER;
          else if (reqDeepPd)  nextState = ST_DPD_ENTER;
        end
      end
      ST_SR_ENTER:    nextState = ST_SR_ACTIVE;
      ST_SR_ACTIVE:   if (reqWake)   nextState = ST_SR_WAIT_CLK;
      ST_SR_WAIT_CLK: if (clkStable) nextState = ST_SR_XSR;
      ST_SR_XSR:      if (xsrZero)   nextState = ST_IDLE;
      ST_DPD_ENTER:   nextState = ST_DPD_ACTIVE;
      ST_DPD_ACTIVE:  if (reqWake)   nextState = ST_DPD_EXIT;
      ST_DPD_EXIT:    if (reinitAck) nextState = ST_IDLE;
      default:        nextState = ST_IDLE;
    endcase
  end

  // Strobes describe the pin levels that belong to nextState.
  always_comb begin
    strobes = '0;
    case (nextState)
      ST_SR_ENTER:  strobes.cmd = CMD_REFRESH;
      ST_DPD_ENTER: strobes.cmd = CMD_DPD;
      default:      strobes.cmd = CMD_NOP;
    endcase
    strobes.ckeHigh = (nextState == ST_IDLE) || (nextState == ST_SR_XSR) ||
                      (nextState == ST_DPD_EXIT);
    strobes.clkOn   = (nextState != ST_SR_ACTIVE);
    strobes.readyOn = (nextState == ST_IDLE);
    strobes.xsrLoad = (state == ST_SR_WAIT_CLK) && (nextState == ST_SR_XSR);
    strobes.xsrTick = (state == ST_SR_XSR) && !xsrZero;
    strobes.lostSet = (state == ST_DPD_ACTIVE) && (nextState == ST_DPD_EXIT);
    strobes.lostClr = (state == ST_DPD_EXIT) && (nextState == ST_IDLE);
  end

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int XSR_CYCLES = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobes,
  output logic      xsrZero,
  output logic      memCsN,
  output logic      memRasN,
  output logic      memCasN,
  output logic      memWeN,
  output logic      memCke,
  output logic      memClkEn,
  output logic      cmdReady,
  output logic      dataLost
);

  localparam int CW = (XSR_CYCLES > 1) ? $clog2(XSR_CYCLES) : 1;
  localparam logic [CW-1:0] XSR_LOAD = CW'(XSR_CYCLES - 1);

  logic [CW-1:0] xsrCnt;
  logic [3:0]    pinReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinReg   <= cmdPins(CMD_NOP);
      memCke   <= 1'b1;
      memClkEn <= 1'b1;
      cmdReady <= 1'b1;
    end else begin
      pinReg   <= cmdPins(strobes.cmd);
      memCke   <= strobes.ckeHigh;
      memClkEn <= strobes.clkOn;
      cmdReady <= strobes.readyOn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                xsrCnt <= '0;
    else if (strobes.xsrLoad) xsrCnt <= XSR_LOAD;
    else if (strobes.xsrTick) xsrCnt <= xsrCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                dataLost <= 1'b0;
    else if (strobes.lostSet) dataLost <= 1'b1;
    else if (strobes.lostClr) dataLost <= 1'b0;
  end

  assign xsrZero = (xsrCnt == '0);
  assign {memCsN, memRasN, memCasN, memWeN} = pinReg;

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int XSR_CYCLES = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqSelfRefresh,
  input  logic reqDeepPd,
  input  logic reqWake,
  input  logic banksIdle,
  input  logic clkStable,
  input  logic reinitAck,
  output logic memCsN,
  output logic memRasN,
  output logic memCasN,
  output logic memWeN,
  output logic memCke,
  output logic memClkEn,
  output logic cmdReady,
  output logic dataLost
);

  dpStrobe_t strobes;
  logic      xsrZero;

  lpm_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqSelfRefresh (reqSelfRefresh),
    .reqDeepPd      (reqDeepPd),
    .reqWake        (reqWake),
    .banksIdle      (banksIdle),
    .clkStable      (clkStable),
    .reinitAck      (reinitAck),
    .xsrZero        (xsrZero),
    .strobes        (strobes)
  );

  lpm_datapath #(.XSR_CYCLES(XSR_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .xsrZero  (xsrZero),
    .memCsN   (memCsN),
    .memRasN  (memRasN),
    .memCasN  (memCasN),
    .memWeN   (memWeN),
    .memCke   (memCke),
    .memClkEn (memClkEn),
    .cmdReady (cmdReady),
    .dataLost (dataLost)
  );

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic clk,
  input logic rstN,
  input logic clkStable,
  input logic reinitAck,
  input logic memCsN,
  input logic memRasN,
  input logic memCasN,
  input logic memWeN,
  input logic memCke,
  input logic memClkEn,
  input logic cmdReady,
  input logic dataLost
);

  logic [3:0] pins;
  assign pins = {memCsN, memRasN, memCasN, memWeN};

  // R11: ready only with CKE high and a NOP on the pins
  p_ready_clean_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (memCke && pins == 4'b0111));

  // R2: refresh-with-CKE-low is followed by CKE still low
  p_sr_entry_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b0001 && !memCke) |=> !memCke);

  // R7: deep power-down encoding always comes with CKE low
  p_dpd_cke_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b0110) |-> !memCke);

  // R4: the memory clock is gated only while CKE is low
  p_gate_cke_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memClkEn |-> !memCke);

  // R5: a self-refresh CKE rise follows a stable, enabled clock
  p_clk_before_cke_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memCke) && !dataLost) |-> ($past(clkStable) && $past(memClkEn)));

  // R8: lost contents keep the controller blocked until acknowledged
  p_lost_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataLost && !reinitAck) |=> (dataLost && !cmdReady));

endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clkStable (clkStable),
  .reinitAck (reinitAck),
  .memCsN    (memCsN),
  .memRasN   (memRasN),
  .memCasN   (memCasN),
  .memWeN    (memWeN),
  .memCke    (memCke),
  .memClkEn  (memClkEn),
  .cmdReady  (cmdReady),
  .dataLost  (dataLost)
);

// File: tb/tb_lpm_seq.sv
`timescale 1ns/1ps
module tb_lpm_seq;

  localparam int XSR = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqSelfRefresh = 1'b0, reqDeepPd = 1'b0, reqWake = 1'b0;
  logic banksIdle = 1'b1, clkStable = 1'b0, reinitAck = 1'b0;
  logic memCsN, memRasN, memCasN, memWeN, memCke, memClkEn, cmdReady, dataLost;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lpm_seq #(.XSR_CYCLES(XSR)) dut (
    .clk(clk), .rstN(rstN),
    .reqSelfRefresh(reqSelfRefresh), .reqDeepPd(reqDeepPd), .reqWake(reqWake),
    .banksIdle(banksIdle), .clkStable(clkStable), .reinitAck(reinitAck),
    .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memCke(memCke), .memClkEn(memClkEn), .cmdReady(cmdReady), .dataLost(dataLost)
  );

  function automatic logic [3:0] pins();
    return {memCsN, memRasN, memCasN, memWeN};
  endfunction

  // Packs {pins, cke, clkEn, ready, lost} for compact compare
  function automatic logic [7:0] snap();
    return {pins(), memCke, memClkEn, cmdReady, dataLost};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset state", snap(), {4'b0111, 1'b1, 1'b1, 1'b1, 1'b0});
  endtask

  task automatic t_busy_holdoff();
    banksIdle = 1'b0;
    for (int i = 0; i < 4; i++) begin
      reqSelfRefresh = i[0];
      reqDeepPd = ~i[0];
      @(negedge clk);
      check("R3 entry held off while banks busy", snap(), {4'b0111, 1'b1, 1'b1, 1'b1, 1'b0});
    end
    reqSelfRefresh = 1'b0;
    reqDeepPd = 1'b0;
    banksIdle = 1'b1;
    @(negedge clk);
  endtask

  task automatic sr_exit_and_count(input string tag);
    int n;
    reqWake = 1'b1;
    @(negedge clk);
    reqWake = 1'b0;
    check({tag, " R4 clock back on, CKE low"}, snap(), {4'b0111, 1'b0, 1'b1, 1'b0, 1'b0});
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check({tag, " R5 CKE low until clock stable"}, {7'd0, memCke}, 8'd0);
    end
    clkStable = 1'b1;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (cmdReady) break;
      if (memCke) begin
        n++;
        check({tag, " R6 NOP with CKE high in exit window"}, snap(), {4'b0111, 1'b1, 1'b1, 1'b0, 1'b0});
      end
    end
    total++;
    if (n != XSR) begin
      bad++;
      $display("FAIL %s R6 exit window actual=%0d expected=%0d", tag, n, XSR);
    end
    check({tag, " R11 ready with CKE high and NOP"}, snap(), {4'b0111, 1'b1, 1'b1, 1'b1, 1'b0});
    clkStable = 1'b0;
  endtask

  task automatic t_self_refresh();
    reqSelfRefresh = 1'b1;
    @(negedge clk);
    reqSelfRefresh = 1'b0;
    check("R2 refresh encoding with CKE low", snap(), {4'b0001, 1'b0, 1'b1, 1'b0, 1'b0});
    @(negedge clk);
    check("R4 clock gated after entry", snap(), {4'b0111, 1'b0, 1'b0, 1'b0, 1'b0});
    reqSelfRefresh = 1'b1;
    reqDeepPd = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 entry requests ignored in self refresh", snap(), {4'b0111, 1'b0, 1'b0, 1'b0, 1'b0});
    end
    reqSelfRefresh = 1'b0;
    reqDeepPd = 1'b0;
    sr_exit_and_count("sr");
  endtask

  task automatic t_deep_pd();
    reqDeepPd = 1'b1;
    @(negedge clk);
    reqDeepPd = 1'b0;
    check("R7 deep power-down encoding with CKE low", snap(), {4'b0110, 1'b0, 1'b1, 1'b0, 1'b0});
    reqSelfRefresh = 1'b1;
    @(negedge clk);
    reqSelfRefresh = 1'b0;
    check("R7 CKE held low in deep power-down", snap(), {4'b0111, 1'b0, 1'b1, 1'b0, 1'b0});
    @(negedge clk);
    check("R10 entry request ignored in deep power-down", snap(), {4'b0111, 1'b0, 1'b1, 1'b0, 1'b0});
    reqWake = 1'b1;
    @(negedge clk);
    reqWake = 1'b0;
    check("R8 wake raises CKE and flags loss", snap(), {4'b0111, 1'b1, 1'b1, 1'b0, 1'b1});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 blocked until acknowledge", snap(), {4'b0111, 1'b1, 1'b1, 1'b0, 1'b1});
    end
    reinitAck = 1'b1;
    @(negedge clk);
    reinitAck = 1'b0;
    check("R8 acknowledge restores ready", snap(), {4'b0111, 1'b1, 1'b1, 1'b1, 1'b0});
  endtask

  task automatic t_priority();
    reqSelfRefresh = 1'b1;
    reqDeepPd = 1'b1;
    @(negedge clk);
    reqSelfRefresh = 1'b0;
    reqDeepPd = 1'b0;
    check("R9 self refresh wins over deep power-down", snap(), {4'b0001, 1'b0, 1'b1, 1'b0, 1'b0});
    @(negedge clk);
    sr_exit_and_count("prio");
  endtask

  task automatic t_wake_idle();
    reqWake = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 wake ignored in idle", snap(), {4'b0111, 1'b1, 1'b1, 1'b1, 1'b0});
    end
    reqWake = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_busy_holdoff();
    t_self_refresh();
    t_deep_pd();
    t_priority();
    t_wake_idle();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule